// File: doc/BRIEF.md
# Time-Stepped Transient Simulation Controller

This block models one pipeline stage in fine time steps, not whole clock cycles. Each cycle of the hardware clock is one time step. A simulated clock period lasts a programmed number of steps. At the start of each simulated period the block asks an external delay-profile store for the path delay of the current input. It adds a signed droop adjustment and saturates the result. That arrival step is then compared against a step counter that runs from zero up to the period length.

The output indicator stays low until the counter reaches the arrival step. It is also held low whenever the external event generator signals an active transient window. At the final step of the period the block samples the indicator. It counts one produced output, and it counts one erroneous output if the indicator was low. It then moves on to the next period.

A start pulse runs a programmed number of periods, after which `done` is raised. A stop pulse abandons the run at once. The tallies can therefore give throughput and error rate against the arrival times, event windows and period length.

Top module: `tstep_sim_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `out_valid`, `period_end` and `dly_req` are 0, `step_cnt` is 0 and both tallies are 0.
- R2: A `start` pulse while idle or done clears both tallies and begins the first period. In every period the block raises `dly_req` with `dly_idx` equal to the period number (counted from 0, modulo 2^IDX_W). It keeps `dly_req` high until the cycle in which `dly_valid` is 1, and captures `dly_data` in that cycle.
- R3: During a period `step_cnt` starts at 0 and rises by exactly 1 per clock up to the effective length Peff. So a period spends Peff+1 cycles running. Peff is `period_len`, except that a `period_len` of 0 is treated as 1.
- R4: The arrival step is `dly_data` plus the two's-complement `droop_adj`, clamped to the range 0 to 65535.
- R5: While a period runs, `out_valid` is 1 exactly when `step_cnt` is at least the arrival step and `evt_active` is 0. Outside a running period it is 0.
- R6: In the cycle where `step_cnt` equals Peff, `period_end` pulses. `prod_cnt` then rises by 1, and `err_cnt` rises by 1 if `out_valid` is 0 in that cycle.
- R7: After `num_periods` periods the block leaves `busy` and holds `done` at 1 until the next `start`. A `num_periods` of 0 goes straight to done.
- R8: A `stop` pulse during a run returns the block to idle on the next clock, with `done` at 0 and both tallies unchanged.
- R9: Both tallies are CNT_W bits wide and stay at all-ones instead of wrapping.
- R10: A `start` pulse while `busy` is ignored: tallies are not cleared and the run continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time step |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| stop | input | 1 | Abandon a run (one-cycle pulse) |
| period_len | input | 16 | Simulated clock period in steps |
| num_periods | input | NP_W | Number of periods in a run |
| droop_adj | input | 16 | Signed adjustment added to each path delay |
| evt_active | input | 1 | Transient event window in progress |
| dly_req | output | 1 | Request for a path delay |
| dly_idx | output | IDX_W | Input index whose delay is requested |
| dly_valid | input | 1 | Delay data is present this cycle |
| dly_data | input | 16 | Path delay in steps |
| step_cnt | output | 16 | Current time step within the period |
| out_valid | output | 1 | Stage output indicator |
| period_end | output | 1 | Pulse at the final step of each period |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished all periods |
| prod_cnt | output | CNT_W | Produced outputs |
| err_cnt | output | CNT_W | Erroneous outputs |

## Verification
The hardest situation to reach is a tally sitting at its ceiling. At 32 bits this would need billions of periods. The bench therefore builds the block with a narrow tally width and runs more one-step periods than the tally can hold, each with a delay past the period, so both tallies must stop at all-ones. The event-window corners are reached by driving `evt_active` from the observed `step_cnt`. This places the window exactly over, or just before, the sampling step.

// File: rtl/tsim_pkg.sv
package tsim_pkg;

    localparam int STEP_W = 16;
    localparam int SUM_W  = STEP_W + 2;

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic clr;
        logic inc_prod;
        logic inc_err;
    } tally_cmd_t;

    // Signed sum of an unsigned delay and a signed adjustment, clamped to step range.
    function automatic step_t sat_arrival(input step_t d, input logic [STEP_W-1:0] adj);
        logic signed [SUM_W-1:0] s;
        s = $signed({2'b00, d}) + $signed({{2{adj[STEP_W-1]}}, adj});
        if (s < 0)
            return '0;
        else if (s > $signed({2'b00, {STEP_W{1'b1}}}))
            return {STEP_W{1'b1}};
        else
            return s[STEP_W-1:0];
    endfunction

endpackage

// File: rtl/tsim_step_ctr.sv
module tsim_step_ctr
    import tsim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  step_t period_len,
    output step_t step,
    output logic  at_end
);

    step_t peff;

    always_comb begin
        peff   = (period_len == '0) ? step_t'(1) : period_len;
        at_end = run && (step == peff);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            step <= '0;
        else if (at_end)
            step <= '0;
        else
            step <= step + step_t'(1);
    end

    // R3: every running step below the end advances by exactly one
    a_r3_step_plus_one: assert property (@(posedge clk) disable iff (rst)
        (run && !at_end) |=> (!run || step == $past(step) + step_t'(1)));

    // R3: the counter never passes the effective period
    a_r3_within_period: assert property (@(posedge clk) disable iff (rst)
        run |-> (step <= peff));

endmodule

// File: rtl/tsim_arrival.sv
module tsim_arrival
    import tsim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  step_t             dly,
    input  logic [STEP_W-1:0] adj,
    output step_t             arr
);

    always_ff @(posedge clk) begin
        if (rst)
            arr <= '0;
        else if (load)
            arr <= sat_arrival(dly, adj);
    end

endmodule

// File: rtl/tsim_tally.sv
module tsim_tally
    import tsim_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  tally_cmd_t       cmd,
    output logic [CNT_W-1:0] prod_cnt,
    output logic [CNT_W-1:0] err_cnt
);

    localparam int NUM_CTR = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NUM_CTR-1:0]  inc;
    logic [CNT_W-1:0]    val [NUM_CTR];

    assign inc = {cmd.inc_err, cmd.inc_prod};

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst || cmd.clr)
                val[g] <= '0;
            else if (inc[g] && val[g] != CNT_MAX)
                val[g] <= val[g] + CNT_W'(1);
        end

        // R9: a tally only moves up, except on clear
        a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
            !$past(cmd.clr) |-> (val[g] >= $past(val[g])));
    end

    assign prod_cnt = val[0];
    assign err_cnt  = val[1];

    // R6: an error is only ever counted together with a produced output
    a_r6_err_with_prod: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmd.clr) && err_cnt != $past(err_cnt)) |->
            (prod_cnt != $past(prod_cnt) || prod_cnt == CNT_MAX));

endmodule

// File: rtl/tsim_seq.sv
module tsim_seq
    import tsim_pkg::*;
#(
    parameter int NP_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [NP_W-1:0]  num_periods,
    input  logic             dly_valid,
    input  logic             at_end,
    input  logic             ind_ok,
    output seq_st_e          st,
    output logic             load,
    output logic [IDX_W-1:0] idx,
    output logic             period_end,
    output tally_cmd_t       tcmd
);

    logic [NP_W-1:0] pidx;
    logic            start_ok;
    logic            last;

    always_comb begin
        start_ok        = start && (st == ST_IDLE || st == ST_DONE);
        load            = (st == ST_LOAD) && dly_valid && !stop;
        period_end      = (st == ST_RUN) && at_end && !stop;
        last            = (pidx + NP_W'(1)) == num_periods;
        idx             = pidx[IDX_W-1:0];
        tcmd.clr        = start_ok;
        tcmd.inc_prod   = period_end;
        tcmd.inc_err    = period_end && !ind_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            pidx <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        pidx <= '0;
                        st   <= (num_periods == '0) ? ST_DONE : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (stop)
                        st <= ST_IDLE;
                    else if (dly_valid)
                        st <= ST_RUN;
                end
                ST_RUN: begin
                    if (stop) begin
                        st <= ST_IDLE;
                    end else if (at_end) begin
                        if (last) begin
                            st <= ST_DONE;
                        end else begin
                            pidx <= pidx + NP_W'(1);
                            st   <= ST_LOAD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7: done only appears after a final period or an empty run
    a_r7_done_source: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_DONE) |-> ($past(period_end) || $past(num_periods == '0)));

    // R2: an unanswered delay request stays up
    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD && !dly_valid && !stop) |=> (st == ST_LOAD));

    // R8: stop during a run lands in idle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (rst)
        (stop && (st == ST_LOAD || st == ST_RUN)) |=> (st == ST_IDLE));

endmodule

// File: rtl/tstep_sim_ctrl.sv
module tstep_sim_ctrl
    import tsim_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NP_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [15:0]       period_len,
    input  logic [NP_W-1:0]   num_periods,
    input  logic [15:0]       droop_adj,
    input  logic              evt_active,
    output logic              dly_req,
    output logic [IDX_W-1:0]  dly_idx,
    input  logic              dly_valid,
    input  logic [15:0]       dly_data,
    output logic [15:0]       step_cnt,
    output logic              out_valid,
    output logic              period_end,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  prod_cnt,
    output logic [CNT_W-1:0]  err_cnt
);

    seq_st_e    st;
    logic       load;
    logic       at_end;
    logic       running;
    step_t      step;
    step_t      arr;
    tally_cmd_t tcmd;

    assign running   = (st == ST_RUN);
    assign out_valid = running && (step >= arr) && !evt_active;
    assign dly_req   = (st == ST_LOAD);
    assign busy      = (st == ST_LOAD) || (st == ST_RUN);
    assign done      = (st == ST_DONE);
    assign step_cnt  = step;

    tsim_seq #(.NP_W(NP_W), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .stop        (stop),
        .num_periods (num_periods),
        .dly_valid   (dly_valid),
        .at_end      (at_end),
        .ind_ok      (out_valid),
        .st          (st),
        .load        (load),
        .idx         (dly_idx),
        .period_end  (period_end),
        .tcmd        (tcmd)
    );

    tsim_step_ctr u_step (
        .clk        (clk),
        .rst        (rst),
        .run        (running),
        .period_len (period_len),
        .step       (step),
        .at_end     (at_end)
    );

    tsim_arrival u_arr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .dly  (dly_data),
        .adj  (droop_adj),
        .arr  (arr)
    );

    tsim_tally #(.CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .cmd      (tcmd),
        .prod_cnt (prod_cnt),
        .err_cnt  (err_cnt)
    );

    // R5: the indicator never shows valid outside a running period
    a_r5_idle_invalid: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid);

    // R1: reset leaves the block idle with empty tallies
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && prod_cnt == '0 && err_cnt == '0));

endmodule

// File: tb/tstep_sim_ctrl_bench.sv
module tstep_sim_ctrl_bench;

    localparam int CLK_NS = 10;
    localparam int CW     = 5;
    localparam int IW     = 4;
    localparam int NV     = 10;
    localparam int WDOG   = 150000;

    // fields: period, delay, droop, event lo, event hi (lo==hi means none)
    localparam logic [79:0] VEC [NV] = '{
        {16'd10,   16'd5,     16'h0000, 16'd0, 16'd0},
        {16'd10,   16'd10,    16'h0000, 16'd0, 16'd0},
        {16'd10,   16'd11,    16'h0000, 16'd0, 16'd0},
        {16'd10,   16'd12,    16'hFFFD, 16'd0, 16'd0},
        {16'd10,   16'd5,     16'h0006, 16'd0, 16'd0},
        {16'd10,   16'd3,     16'h0000, 16'd8, 16'd11},
        {16'd10,   16'd3,     16'h0000, 16'd4, 16'd9},
        {16'd1000, 16'd999,   16'h0000, 16'd0, 16'd0},
        {16'd20,   16'd65530, 16'h0064, 16'd0, 16'd0},
        {16'd20,   16'd5,     16'hFFF6, 16'd0, 16'd0}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          start = 0, stop = 0;
    logic [15:0]   period_len = 16'd10;
    logic [31:0]   num_periods = 32'd1;
    logic [15:0]   droop_adj = '0;
    logic          evt_active;
    logic          dly_req;
    logic [IW-1:0] dly_idx;
    logic          dly_valid = 0;
    logic [15:0]   dly_data = '0;
    logic [15:0]   step_cnt;
    logic          out_valid, period_end, busy, done;
    logic [CW-1:0] prod_cnt, err_cnt;

    logic [15:0]   mem [16];
    int            ev_lo = 0, ev_hi = 0;
    int            checks = 0, fails = 0;
    int            exp_arr = 0;
    bit            mon_en = 0;
    int            mon_bad = 0, run_cyc = 0;
    bit            finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign evt_active = (int'(step_cnt) >= ev_lo) && (int'(step_cnt) < ev_hi);

    tstep_sim_ctrl #(.CNT_W(CW), .NP_W(32), .IDX_W(IW)) u_tstep_sim_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .period_len(period_len), .num_periods(num_periods),
        .droop_adj(droop_adj), .evt_active(evt_active),
        .dly_req(dly_req), .dly_idx(dly_idx), .dly_valid(dly_valid),
        .dly_data(dly_data), .step_cnt(step_cnt), .out_valid(out_valid),
        .period_end(period_end), .busy(busy), .done(done),
        .prod_cnt(prod_cnt), .err_cnt(err_cnt)
    );

    // delay store model: answers one half cycle after a request is seen
    always @(negedge clk) begin
        dly_valid <= dly_req && !dly_valid;
        dly_data  <= mem[dly_idx];
    end

    // R5 / R3 monitor over running cycles
    always @(negedge clk) begin
        if (mon_en && busy && !dly_req) begin
            run_cyc++;
            if (out_valid !== ((int'(step_cnt) >= exp_arr) && !evt_active))
                mon_bad++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat_ref(input int d, input int a);
        int s = d + a;
        if (s < 0) return 0;
        if (s > 65535) return 65535;
        return s;
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!done && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int t = 0; t < WDOG; t++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected 0", WDOG);
        report();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'd0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check(!busy && !done && !out_valid && !period_end && !dly_req, "R1 flags",
              {busy, done, out_valid, period_end, dly_req}, 0);
        check(step_cnt == 0 && prod_cnt == 0 && err_cnt == 0, "R1 counts",
              step_cnt + prod_cnt + err_cnt, 0);

        // table walk: one period per vector
        for (int v = 0; v < NV; v++) begin
            int p, d, a, peff, exp_err;
            p = int'(VEC[v][79:64]);
            d = int'(VEC[v][63:48]);
            a = int'($signed(VEC[v][47:32]));
            ev_lo = int'(VEC[v][31:16]);
            ev_hi = int'(VEC[v][15:0]);
            peff = (p == 0) ? 1 : p;
            exp_arr = sat_ref(d, a);
            exp_err = ((exp_arr <= peff) && !(peff >= ev_lo && peff < ev_hi)) ? 0 : 1;
            @(negedge clk);
            mem[0] = 16'(d);
            period_len = 16'(p);
            droop_adj = 16'(a);
            num_periods = 1;
            mon_bad = 0;
            run_cyc = 0;
            mon_en = 1;
            pulse_start();
            wait_end();
            mon_en = 0;
            check(done == 1, "R7 done after run", done, 1);
            check(prod_cnt == 1, "R6 produced", prod_cnt, 1);
            check(int'(err_cnt) == exp_err, "R6/R4 error tally", err_cnt, exp_err);
            check(mon_bad == 0, "R5 indicator per step", mon_bad, 0);
            check(run_cyc == peff + 1, "R3 period length", run_cyc, peff + 1);
            ev_lo = 0;
            ev_hi = 0;
        end

        // R3: zero period treated as one
        mem[0] = 16'd1; period_len = 0; droop_adj = 0; num_periods = 1;
        exp_arr = 1; run_cyc = 0; mon_bad = 0; mon_en = 1;
        pulse_start(); wait_end(); mon_en = 0;
        check(run_cyc == 2, "R3 zero period", run_cyc, 2);
        check(err_cnt == 0, "R3 zero period err", err_cnt, 0);
        mem[0] = 16'd2;
        pulse_start(); wait_end();
        check(err_cnt == 1, "R3 zero period late", err_cnt, 1);

        // R2: multi-period run, delay indexed by period number
        mem[0] = 16'd2; mem[1] = 16'd9; mem[2] = 16'd3; mem[3] = 16'd12;
        period_len = 8; num_periods = 4;
        pulse_start();
        check(dly_req == 1 && dly_idx == 0, "R2 first request", dly_idx, 0);
        wait_end();
        check(prod_cnt == 4, "R2 multi produced", prod_cnt, 4);
        check(err_cnt == 2, "R2 multi errors", err_cnt, 2);

        // R7: zero periods goes straight to done
        num_periods = 0;
        pulse_start();
        check(done == 1 && !busy, "R7 empty run", done, 1);
        check(prod_cnt == 0, "R2 clear on start", prod_cnt, 0);

        // R10: start while busy is ignored
        num_periods = 3; period_len = 8;
        pulse_start();
        while (prod_cnt != 1) @(negedge clk);
        start = 1;
        @(negedge clk) start = 0;
        check(prod_cnt == 1 && busy, "R10 start ignored", prod_cnt, 1);
        wait_end();
        check(prod_cnt == 3, "R10 run completes", prod_cnt, 3);

        // R8: stop aborts and keeps tallies
        num_periods = 100;
        pulse_start();
        while (prod_cnt != 2) @(negedge clk);
        stop = 1;
        @(negedge clk) stop = 0;
        check(!busy && !done, "R8 stopped idle", {busy, done}, 0);
        check(prod_cnt == 2, "R8 tally kept", prod_cnt, 2);
        repeat (20) @(negedge clk);
        check(prod_cnt == 2 && !dly_req, "R8 stays idle", prod_cnt, 2);

        // R9: tallies stay at all-ones
        for (int i = 0; i < 16; i++) mem[i] = 16'd5;
        period_len = 1; num_periods = 40;
        pulse_start(); wait_end();
        check(prod_cnt == {CW{1'b1}}, "R9 produced saturates", prod_cnt, (1 << CW) - 1);
        check(err_cnt == {CW{1'b1}}, "R9 errors saturate", err_cnt, (1 << CW) - 1);

        // R1: reset mid-run returns to idle
        num_periods = 50;
        pulse_start();
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        check(!busy && prod_cnt == 0 && err_cnt == 0, "R1 reset mid-run", prod_cnt, 0);

        report();
    end

endmodule